// File: doc/BRIEF.md
# Video Sync Processor Control Register Bank

This block is the serial control port of a video sync and deflection processor. It is a two-wire (I2C) slave. It samples SCL and SDA with the system clock. It decodes one 7-bit slave address, chosen from two by a strap input. Write transactions carry a subaddress byte followed by data bytes. The data bytes land in twelve configuration registers, and the pointer auto-increments after each data byte. A read transaction returns one status byte. That byte merges live status inputs with two sticky fault flags held inside the block.

The block also enforces the power-up ordering of the deflection stage. A write to the mode register starts line-oscillator calibration through a one-cycle strobe. That strobe is issued only once the input/crystal register has been written since reset. The horizontal drive enable stays off while a power-up flag or an over-voltage flag is latched, or while the run bit is clear. Only a later write of the mode register with the run bit set turns the drive back on.

Top module: `vsp_ctrl_regs`

## Requirements
- R1: The slave ACKs 7-bit address 0x45 when `addr_strap_i` is 0 and 0x47 when it is 1 (bit 1 of the address follows the strap). It NACKs every other address and leaves all registers unchanged.
- R2: In a write, the first byte after the address sets the subaddress pointer. Each following data byte is stored at the pointer, and the pointer then increments by one.
- R3: Subaddresses 0x00 and 0x01 store all 8 bits. Subaddresses 0x02 to 0x0A store bits 5:0, with bits 7:6 reading as 0. Subaddress 0x0B stores bits 7 and 5:0, with bit 6 reading as 0.
- R4: Data bytes at subaddresses 0x0C to 0x0F are ACKed, change no register, and still advance the pointer.
- R5: A read returns the status byte {pwr_flag, field_60hz_i, sync_seen_i, locked_i, ovp_flag, std_code_i[2:0]} from MSB to LSB, and the byte is ACKed.
- R6: A write to subaddress 0x01 gives a `cal_start_o` pulse exactly one cycle wide. The pulse appears only if subaddress 0x00 has been written since reset; otherwise the write gives no pulse.
- R7: Reset sets the power-up flag. The flag clears only on a write to 0x01 with bit 4 (run) equal to 1 that follows a status read made while the flag was set.
- R8: The over-voltage flag sets while `ovp_trip_i` is high and stays set after the input falls. It clears on a write to 0x01 with run = 1 while `ovp_trip_i` is low.
- R9: `hdrive_en_o` is 0 after reset. It becomes 1 only on a write to 0x01 with run = 1 that leaves both flags clear. It drops when 0x01 is written with run = 0 or when `ovp_trip_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_strap_i | input | 1 | Selects slave address bit 1 |
| field_60hz_i | input | 1 | Status: field rate indication |
| sync_seen_i | input | 1 | Status: signal present |
| locked_i | input | 1 | Status: phase loop locked |
| ovp_trip_i | input | 1 | Over-voltage detector |
| std_code_i | input | 3 | Status: identified standard code |
| cfg_in_o | output | 8 | Register 0x00 |
| cfg_mode_o | output | 8 | Register 0x01 |
| adj_o | output | 80 | Registers 0x02..0x0B, byte k-2 holds subaddress k |
| cal_start_o | output | 1 | Calibration start strobe |
| hdrive_en_o | output | 1 | Horizontal drive enable |

## Verification
The bench writes the mode register before the input register exists. A design without the ordering gate would fire `cal_start_o` there, and a design that forgets the read precondition would clear the power-up flag and enable the drive. Masked and unused subaddresses are written with all-ones inside one auto-increment burst. A bad mask shows as stray upper bits, and a pointer that stops or wraps at 0x0C corrupts a neighbour. Over-voltage is raised, released and cleared in separate steps. A flag that follows the input instead of latching, or that clears while the trip is still high, gives a wrong status bit or a live drive enable. The strap is toggled to show that the second address answers and the first is refused.

// File: rtl/vsp_regs_pkg.sv
package vsp_regs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK
  } i2c_st_e;

  localparam int RUN_BIT = 4;

  // storage mask per subaddress
  function automatic logic [7:0] field_mask(int idx);
    if (idx < 2)        return 8'hFF;
    else if (idx <= 10) return 8'h3F;
    else if (idx == 11) return 8'hBF;
    else                return 8'h00;
  endfunction
endpackage

// File: rtl/vsp_i2c_slave.sv
module vsp_i2c_slave
  import vsp_regs_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [AW-1:0] dev_addr_i,
  input  logic [7:0]    tx_byte_i,
  output logic          sda_oe_o,
  output logic          rx_valid_o,
  output logic          rx_first_o,
  output logic [7:0]    rx_byte_o,
  output logic          tx_load_o
);
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl, sda;
  logic       scl_rise, scl_fall, start_c, stop_c;
  i2c_st_e    st_q;
  logic [3:0] cnt_q;
  logic [7:0] sr_q;
  logic       rw_q, first_q, mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_sy[1];
      sda_d  <= sda_sy[1];
    end
  end

  assign scl      = scl_sy[1];
  assign sda      = sda_sy[1];
  assign scl_rise = scl & ~scl_d;
  assign scl_fall = ~scl & scl_d;
  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; rw_q <= 1'b0;
      first_q <= 1'b0; mack_q <= 1'b0; sda_oe_o <= 1'b0;
      rx_valid_o <= 1'b0; rx_first_o <= 1'b0; rx_byte_o <= '0; tx_load_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      if (start_c) begin
        st_q <= ST_ADDR; cnt_q <= '0; sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st_q <= ST_IDLE; sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sr_q <= {sr_q[6:0], sda}; cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (sr_q[7:1] == dev_addr_i) begin
                sda_oe_o <= 1'b1; rw_q <= sr_q[0]; first_q <= 1'b1; st_q <= ST_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sr_q <= tx_byte_i; sda_oe_o <= ~tx_byte_i[7];
                tx_load_o <= 1'b1; st_q <= ST_TX;
              end else begin
                sda_oe_o <= 1'b0; st_q <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sr_q <= {sr_q[6:0], sda}; cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              rx_valid_o <= 1'b1; rx_byte_o <= sr_q; rx_first_o <= first_q;
              first_q <= 1'b0; sda_oe_o <= 1'b1; st_q <= ST_ACK;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0; st_q <= ST_MACK;
              end else begin
                sr_q <= {sr_q[6:0], 1'b0}; sda_oe_o <= ~sr_q[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda;
            end else if (scl_fall) begin
              if (mack_q) begin
                sr_q <= tx_byte_i; sda_oe_o <= ~tx_byte_i[7];
                tx_load_o <= 1'b1; cnt_q <= '0; st_q <= ST_TX;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_rx_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_ack_after_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> sda_oe_o);
endmodule

// File: rtl/vsp_reg_bank.sv
module vsp_reg_bank
  import vsp_regs_pkg::*;
#(
  parameter int NUM_REG = 12,
  parameter int PTR_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_valid_i,
  input  logic               rx_first_i,
  input  logic [7:0]         rx_byte_i,
  output logic [NUM_REG*8-1:0] regs_o,
  output logic               wr_in_o,
  output logic               wr_mode_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             data_wr;

  assign data_wr   = rx_valid_i & ~rx_first_i;
  assign wr_in_o   = data_wr && ptr_q == PTR_W'(0);
  assign wr_mode_o = data_wr && ptr_q == PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (rx_valid_i)  ptr_q <= rx_first_i ? PTR_W'(rx_byte_i) : ptr_q + PTR_W'(1);
  end

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    localparam logic [7:0] MASK = field_mask(k);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (data_wr && ptr_q == PTR_W'(k))     q <= rx_byte_i & MASK;
    end
    assign regs_o[8*k +: 8] = q;
    assert_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q & ~MASK) == 8'h00);
  end
endmodule

// File: rtl/vsp_fault_ctl.sv
module vsp_fault_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_in_i,
  input  logic wr_mode_i,
  input  logic run_i,
  input  logic tx_load_i,
  input  logic ovp_trip_i,
  output logic pwr_flag_o,
  output logic ovp_flag_o,
  output logic cal_start_o,
  output logic hdrive_en_o
);
  logic seen_q, armed_q;
  logic pwr_nxt, ovp_nxt;

  assign pwr_nxt = (wr_mode_i & run_i & armed_q) ? 1'b0 : pwr_flag_o;
  assign ovp_nxt = ovp_trip_i ? 1'b1 : ((wr_mode_i & run_i) ? 1'b0 : ovp_flag_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0; armed_q <= 1'b0; pwr_flag_o <= 1'b1; ovp_flag_o <= 1'b0;
      cal_start_o <= 1'b0; hdrive_en_o <= 1'b0;
    end else begin
      seen_q      <= seen_q | wr_in_i;
      cal_start_o <= wr_mode_i & seen_q;
      armed_q     <= pwr_nxt & (armed_q | (tx_load_i & pwr_flag_o));
      pwr_flag_o  <= pwr_nxt;
      ovp_flag_o  <= ovp_nxt;
      if (wr_mode_i) hdrive_en_o <= run_i & ~pwr_nxt & ~ovp_nxt;
      else           hdrive_en_o <= hdrive_en_o & ~ovp_trip_i;
    end
  end

  assert_cal_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> seen_q);
  assert_cal_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_start_o);
  assert_pwr_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_flag_o) |-> $past(wr_mode_i && run_i));
  assert_ovp_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_trip_i |=> ovp_flag_o);
  assert_drive_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdrive_en_o |-> !pwr_flag_o && !ovp_flag_o);
  assert_drive_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hdrive_en_o) |-> $past(wr_mode_i && run_i));
endmodule

// File: rtl/vsp_ctrl_regs.sv
module vsp_ctrl_regs
  import vsp_regs_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h45,
  parameter int         NUM_REG   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe_o,
  input  logic                     addr_strap_i,
  input  logic                     field_60hz_i,
  input  logic                     sync_seen_i,
  input  logic                     locked_i,
  input  logic                     ovp_trip_i,
  input  logic [2:0]               std_code_i,
  output logic [7:0]               cfg_in_o,
  output logic [7:0]               cfg_mode_o,
  output logic [(NUM_REG-2)*8-1:0] adj_o,
  output logic                     cal_start_o,
  output logic                     hdrive_en_o
);
  localparam int ADJ_W = (NUM_REG - 2) * 8;

  logic [6:0]           dev_addr;
  logic [7:0]           status;
  logic                 rx_valid, rx_first, tx_load;
  logic [7:0]           rx_byte;
  logic [NUM_REG*8-1:0] regs;
  logic                 wr_in, wr_mode, pwr_flag, ovp_flag;

  assign dev_addr = {ADDR_BASE[6:2], addr_strap_i, ADDR_BASE[0]};
  assign status   = {pwr_flag, field_60hz_i, sync_seen_i, locked_i, ovp_flag, std_code_i};

  vsp_i2c_slave #(.AW(7)) u_slave (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .dev_addr_i (dev_addr),
    .tx_byte_i  (status),
    .sda_oe_o,
    .rx_valid_o (rx_valid),
    .rx_first_o (rx_first),
    .rx_byte_o  (rx_byte),
    .tx_load_o  (tx_load)
  );

  vsp_reg_bank #(.NUM_REG(NUM_REG), .PTR_W(8)) u_bank (
    .clk_i, .rst_ni,
    .rx_valid_i (rx_valid),
    .rx_first_i (rx_first),
    .rx_byte_i  (rx_byte),
    .regs_o     (regs),
    .wr_in_o    (wr_in),
    .wr_mode_o  (wr_mode)
  );

  vsp_fault_ctl u_fault (
    .clk_i, .rst_ni,
    .wr_in_i     (wr_in),
    .wr_mode_i   (wr_mode),
    .run_i       (rx_byte[RUN_BIT]),
    .tx_load_i   (tx_load),
    .ovp_trip_i,
    .pwr_flag_o  (pwr_flag),
    .ovp_flag_o  (ovp_flag),
    .cal_start_o,
    .hdrive_en_o
  );

  assign cfg_in_o   = regs[7:0];
  assign cfg_mode_o = regs[15:8];
  assign adj_o      = regs[16 +: ADJ_W];

  assert_run_mirror_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdrive_en_o |-> cfg_mode_o[RUN_BIT]);
endmodule

// File: tb/vsp_ctrl_regs_test.sv
module vsp_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, strap = 0, ovp = 0;
  logic sda_oe, cal_start, hdrive;
  logic [7:0] cfg_in, cfg_mode;
  logic [79:0] adj;
  wire sda_line = sda_m & ~sda_oe;
  int checks = 0, errors = 0, cal_hi = 0, cal_rises = 0;
  logic cal_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsp_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_strap_i(strap), .field_60hz_i(1'b1), .sync_seen_i(1'b0), .locked_i(1'b1),
    .ovp_trip_i(ovp), .std_code_i(3'b101), .cfg_in_o(cfg_in), .cfg_mode_o(cfg_mode),
    .adj_o(adj), .cal_start_o(cal_start), .hdrive_en_o(hdrive)
  );

  always @(posedge clk) begin
    cal_d <= cal_start;
    if (cal_start) cal_hi <= cal_hi + 1;
    if (cal_start && !cal_d) cal_rises <= cal_rises + 1;
  end

  // subaddress, data, expected stored value
  localparam logic [23:0] VEC [8] = '{
    {8'h00, 8'hA5, 8'hA5}, {8'h02, 8'hFF, 8'h3F}, {8'h05, 8'h2A, 8'h2A},
    {8'h0A, 8'hC1, 8'h01}, {8'h0B, 8'hFF, 8'hBF}, {8'h0B, 8'h40, 8'h00},
    {8'h07, 8'h15, 8'h15}, {8'h00, 8'h3C, 8'h3C}
  };

  function automatic logic [7:0] reg_at(int k);
    if (k == 0) return cfg_in;
    if (k == 1) return cfg_mode;
    return adj[8*(k-2) +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp; repeat (HALF_BIT) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; hp; sda_m = 0; hp; scl_m = 0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 0; hp; scl_m = 1; hp; sda_m = 1; hp; hp;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1; hp; scl_m = 0;
    end
    hp; sda_m = 1; hp; scl_m = 1; hp; ack = ~sda_line; scl_m = 0; hp;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic nack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hp; scl_m = 1; hp; b[i] = sda_line; scl_m = 0;
    end
    hp; sda_m = nack; hp; scl_m = 1; hp; scl_m = 0; hp; sda_m = 1;
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] sub,
                        input logic [7:0] d, output logic ack_all);
    logic a0, a1, a2;
    bus_start; wbyte({dev, 1'b0}, a0); wbyte(sub, a1); wbyte(d, a2); bus_stop;
    ack_all = a0 & a1 & a2;
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic a;
    bus_start; wbyte({strap ? 7'h47 : 7'h45, 1'b1}, a); rbyte(s, 1'b1); bus_stop;
    chk("R5 read ack", a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, a;
    logic [7:0] s;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    chk("R9 reset drive", hdrive, 0);
    chk("R3 reset cfg", {cfg_in, cfg_mode}, 0);

    // mode write before input register: no calibration, drive held by power flag
    wr_reg(7'h45, 8'h01, 8'h10, ack);
    chk("R1 ack", ack, 1);
    chk("R2 mode stored", cfg_mode, 8'h10);
    chk("R6 no cal before input reg", cal_rises, 0);
    chk("R7 drive off without read", hdrive, 0);
    rd_status(s);
    chk("R5/R7 status after reset", s, 8'hD5);

    for (int i = 0; i < 8; i++) begin
      wr_reg(7'h45, VEC[i][23:16], VEC[i][15:8], ack);
      chk("R2 vector ack", ack, 1);
      chk("R3 vector field", reg_at(int'(VEC[i][23:16])), VEC[i][7:0]);
    end

    wr_reg(7'h45, 8'h01, 8'h10, ack);
    chk("R6 cal after input reg", cal_rises, 1);
    chk("R6 cal one cycle", cal_hi, 1);
    chk("R7/R9 drive on", hdrive, 1);
    rd_status(s);
    chk("R7 power flag cleared", s, 8'h55);

    // burst across the unused range
    bus_start; wbyte({7'h45, 1'b0}, ack); wbyte(8'h09, a); ack &= a;
    wbyte(8'h11, a); ack &= a; wbyte(8'h22, a); ack &= a; wbyte(8'hFF, a); ack &= a;
    wbyte(8'hFF, a); ack &= a; wbyte(8'hFF, a); ack &= a; bus_stop;
    chk("R4 burst acks", ack, 1);
    chk("R2 burst 09", reg_at(9), 8'h11);
    chk("R2 burst 0A", reg_at(10), 8'h22);
    chk("R3 burst 0B", reg_at(11), 8'hBF);
    chk("R4 no spill", {cfg_in, cfg_mode}, {8'h3C, 8'h10});
    wr_reg(7'h45, 8'h0D, 8'h77, ack);
    chk("R4 unused ack", ack, 1);
    chk("R4 unused no effect", {reg_at(11), reg_at(2), cfg_in}, {8'hBF, 8'h3F, 8'h3C});

    wr_reg(7'h46, 8'h03, 8'h2B, ack);
    chk("R1 wrong addr nack", ack, 0);
    chk("R1 wrong addr no write", reg_at(3), 8'h00);
    strap = 1;
    wr_reg(7'h47, 8'h03, 8'h2B, ack);
    chk("R1 strap addr ack", ack, 1);
    chk("R1 strap addr write", reg_at(3), 8'h2B);
    wr_reg(7'h45, 8'h03, 8'h01, ack);
    chk("R1 base addr refused", {7'd0, ack, reg_at(3)}, {8'd0, 8'h2B});

    // over-voltage latch
    ovp = 1; repeat (20) @(negedge clk);
    chk("R9 drive drops on trip", hdrive, 0);
    wr_reg(7'h47, 8'h01, 8'h10, ack);
    chk("R8 no clear while high", hdrive, 0);
    ovp = 0; repeat (20) @(negedge clk);
    rd_status(s);
    chk("R8 flag latched", s, 8'h5D);
    wr_reg(7'h47, 8'h01, 8'h10, ack);
    rd_status(s);
    chk("R8 flag cleared", s, 8'h55);
    chk("R9 drive back on", hdrive, 1);
    wr_reg(7'h47, 8'h01, 8'h00, ack);
    chk("R9 run bit off", hdrive, 0);
    chk("R6 cal per mode write", cal_rises, 4);
    chk("R6 pulses single", cal_hi, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule